// File: doc/BRIEF.md
# Single-Wire Register Access Host

This block is the host end of a one-wire, return-to-one serial link to a register-based slave device. A client presents a request with a direction, a 7-bit register address and, for writes, an 8-bit data value. The block turns the request into timed bit frames on an open-drain line: it pulls the line low through `drive_low` and watches the shared line through `line_in`. For a write it sends a command byte followed by a data byte. For a read it sends the command byte, then releases the line and decodes the eight frames the slave returns by measuring how long each one holds the line low.

The link has no framing recovery of its own, so the host resynchronises the slave with a long low pulse, called a break. It sends a break before the first access after reset and before the first access after an error. If the slave stays silent past a response timeout, the host sends a break and resends the command once. A second silent period ends the access with an error. Every timing is a clock-count parameter, so the same logic fits any system clock while the frame period keeps the link at or below 5 kbit/s.

Top module: `swh_host`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `drive_low`, `busy`, `done` and `error` are 0 and `rdata` is 0.
- R2: The first access after reset starts with a break: the line is pulled low for BREAK_CLKS cycles and then released for BRKREC_CLKS cycles. The first command frame follows at once.
- R3: The command byte carries the direction in bit 7 (1 = write, 0 = read) and the address in bits 6:0. It is sent least significant bit first, as 8 frames.
- R4: Every bit frame lasts exactly CYCLE_CLKS cycles and begins with the line pulled low. A 1 holds the line low for LOW1_CLKS cycles and a 0 for LOW0_CLKS cycles. The line is then released for the rest of the frame.
- R5: For a write, the data byte follows the command byte with no gap, least significant bit first. `done` is a one-cycle pulse in the cycle after the last data frame.
- R6: For a read, each slave frame is decoded from its low time in clock cycles. A low time shorter than THRESH_CLKS is a 1 and any longer one is a 0. The first frame is bit 0. `rdata` changes only in the cycle where `done` is high.
- R7: If no falling edge arrives within TIMEOUT_CLKS cycles after the host releases the line, or after the previous slave frame ends, the host sends a break and resends the command. This happens once per access. The break starts exactly TIMEOUT_CLKS cycles after the release.
- R8: A second timeout in the same access gives a one-cycle `error` pulse instead of `done`, TIMEOUT_CLKS cycles after the release. The next access then starts with a break again.
- R9: `busy` rises in the cycle after a request is accepted. It falls in the cycle where `done` or `error` pulses. Requests presented while `busy` is high are ignored and do not change the line activity.
- R10: An access that follows a successful access starts directly with its command frame, with no break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe; taken only while `busy` is low |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Data byte for a write |
| line_in | input | 1 | State of the shared serial line, asynchronous |
| drive_low | output | 1 | 1 pulls the shared line low; 0 releases it |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse when an access completes |
| error | output | 1 | One-cycle pulse when an access fails after its retry |
| rdata | output | DATA_W | Last byte read, updated with `done` |

## Verification
The bench builds the block with BREAK_CLKS=30, BRKREC_CLKS=10, LOW1_CLKS=4, LOW0_CLKS=14, CYCLE_CLKS=20, TIMEOUT_CLKS=40 and THRESH_CLKS=7. With these values a full access, a retried read and a read that fails twice each take only a few hundred cycles. The exact break, frame and timeout edges can therefore be predicted and compared on every clock. The bench's slave answers with 3-cycle and 12-cycle low pulses, one on each side of the decode threshold. It can stay silent for one command or for both, which exercises the single-retry and error paths.

// File: rtl/swh_pkg.sv
package swh_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_BREAK,
    S_CMD,
    S_WDATA,
    S_RX
  } swh_state_e;
endpackage

// File: rtl/swh_frame_gen.sv
// Produces one timed low-then-released frame per start strobe: either a data
// bit frame or a break. A start in the cycle where fin is high chains frames
// back to back with no idle cycle between them.
module swh_frame_gen #(
  parameter int BREAK_CLKS  = 9500,
  parameter int BRKREC_CLKS = 2000,
  parameter int LOW1_CLKS   = 2500,
  parameter int LOW0_CLKS   = 7500,
  parameter int CYCLE_CLKS  = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic is_break,
  input  logic bit_val,
  output logic drive_low,
  output logic fin
);
  localparam int BRK_TOTAL = BREAK_CLKS + BRKREC_CLKS;
  localparam int LONGEST   = (BRK_TOTAL > CYCLE_CLKS) ? BRK_TOTAL : CYCLE_CLKS;
  localparam int CW        = $clog2(LONGEST + 1);

  logic          active;
  logic [CW-1:0] cnt;
  logic [CW-1:0] low_len;
  logic [CW-1:0] tot_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      cnt       <= '0;
      low_len   <= '0;
      tot_len   <= '0;
      drive_low <= 1'b0;
    end else if (start) begin
      active    <= 1'b1;
      cnt       <= CW'(1);
      low_len   <= is_break ? CW'(BREAK_CLKS) : (bit_val ? CW'(LOW1_CLKS) : CW'(LOW0_CLKS));
      tot_len   <= is_break ? CW'(BRK_TOTAL) : CW'(CYCLE_CLKS);
      drive_low <= 1'b1;
    end else if (active) begin
      if (cnt == tot_len) begin
        active    <= 1'b0;
        drive_low <= 1'b0;
      end else begin
        cnt       <= cnt + 1'b1;
        drive_low <= (cnt < low_len);
      end
    end
  end

  assign fin = active && (cnt == tot_len);
endmodule

// File: rtl/swh_pulse_meter.sv
// Synchronises the line, measures the low time of each returned frame and
// flags a silent line after a timeout.
module swh_pulse_meter #(
  parameter int TIMEOUT_CLKS = 25000,
  parameter int THRESH_CLKS  = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic enable,
  input  logic line_in,
  output logic bit_valid,
  output logic bit_val,
  output logic timeout
);
  localparam int TW = $clog2(TIMEOUT_CLKS + 1);
  localparam int LW = $clog2(THRESH_CLKS + 1);

  logic [2:0]    sync;
  logic          line_s;
  logic          line_d;
  logic          falling;
  logic          measuring;
  logic [TW-1:0] tcnt;
  logic [LW-1:0] lcnt;

  always_ff @(posedge clk) begin
    if (rst) sync <= 3'b111;
    else     sync <= {sync[1:0], line_in};
  end

  assign line_s  = sync[1];
  assign line_d  = sync[2];
  assign falling = line_d & ~line_s;

  assign timeout   = enable & ~measuring & ~falling & (tcnt == TW'(TIMEOUT_CLKS - 1));
  assign bit_valid = enable & measuring & line_s;
  assign bit_val   = (lcnt < LW'(THRESH_CLKS));

  always_ff @(posedge clk) begin
    if (rst || arm) begin
      measuring <= 1'b0;
      tcnt      <= '0;
      lcnt      <= '0;
    end else if (enable) begin
      if (!measuring) begin
        if (falling) begin
          measuring <= 1'b1;
          lcnt      <= LW'(1);
          tcnt      <= '0;
        end else if (!timeout) begin
          tcnt <= tcnt + 1'b1;
        end
      end else if (line_s) begin
        measuring <= 1'b0;
        tcnt      <= '0;
      end else if (lcnt != LW'(THRESH_CLKS)) begin
        lcnt <= lcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/swh_host.sv
module swh_host
  import swh_pkg::*;
#(
  parameter int ADDR_W       = 7,
  parameter int DATA_W       = 8,
  parameter int BREAK_CLKS   = 9500,
  parameter int BRKREC_CLKS  = 2000,
  parameter int LOW1_CLKS    = 2500,
  parameter int LOW0_CLKS    = 7500,
  parameter int CYCLE_CLKS   = 10000,
  parameter int TIMEOUT_CLKS = 25000,
  parameter int THRESH_CLKS  = 5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              line_in,
  output logic              drive_low,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [DATA_W-1:0] rdata
);
  localparam int CMD_W = ADDR_W + 1;
  localparam int MAXW  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int IW    = $clog2(MAXW);
  localparam logic [IW-1:0] LAST_CMD  = IW'(CMD_W - 1);
  localparam logic [IW-1:0] LAST_DATA = IW'(DATA_W - 1);

  swh_state_e        state;
  logic [CMD_W-1:0]  cmd_q;
  logic [CMD_W-1:0]  req_cmd;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rx_shift;
  logic [DATA_W-1:0] rx_next;
  logic [IW-1:0]     idx;
  logic [IW-1:0]     idx_nx;
  logic              is_write;
  logic              retried;
  logic              synced;

  logic fg_start, fg_brk, fg_bit, fg_fin;
  logic rx_arm, rx_en, rx_valid, rx_bit, rx_to;

  assign req_cmd = {req_write, req_addr};
  assign idx_nx  = idx + 1'b1;
  assign rx_en   = (state == S_RX);
  assign rx_next = {rx_bit, rx_shift[DATA_W-1:1]};

  // Next-frame request, evaluated in the cycle the current frame ends.
  always_comb begin
    fg_start = 1'b0;
    fg_brk   = 1'b0;
    fg_bit   = 1'b0;
    rx_arm   = 1'b0;
    case (state)
      S_IDLE: begin
        if (req_valid) begin
          fg_start = 1'b1;
          fg_brk   = ~synced;
          fg_bit   = req_cmd[0];
        end
      end
      S_BREAK: begin
        if (fg_fin) begin
          fg_start = 1'b1;
          fg_bit   = cmd_q[0];
        end
      end
      S_CMD: begin
        if (fg_fin) begin
          if (idx == LAST_CMD) begin
            if (is_write) begin
              fg_start = 1'b1;
              fg_bit   = wdata_q[0];
            end else begin
              rx_arm = 1'b1;
            end
          end else begin
            fg_start = 1'b1;
            fg_bit   = cmd_q[idx_nx];
          end
        end
      end
      S_WDATA: begin
        if (fg_fin && idx != LAST_DATA) begin
          fg_start = 1'b1;
          fg_bit   = wdata_q[idx_nx];
        end
      end
      S_RX: begin
        if (!rx_valid && rx_to && !retried) begin
          fg_start = 1'b1;
          fg_brk   = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cmd_q    <= '0;
      wdata_q  <= '0;
      rx_shift <= '0;
      idx      <= '0;
      is_write <= 1'b0;
      retried  <= 1'b0;
      synced   <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
      rdata    <= '0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            busy     <= 1'b1;
            cmd_q    <= req_cmd;
            wdata_q  <= req_wdata;
            is_write <= req_write;
            retried  <= 1'b0;
            idx      <= '0;
            state    <= synced ? S_CMD : S_BREAK;
          end
        end
        S_BREAK: begin
          if (fg_fin) begin
            synced <= 1'b1;
            idx    <= '0;
            state  <= S_CMD;
          end
        end
        S_CMD: begin
          if (fg_fin) begin
            if (idx == LAST_CMD) begin
              idx   <= '0;
              state <= is_write ? S_WDATA : S_RX;
            end else begin
              idx <= idx_nx;
            end
          end
        end
        S_WDATA: begin
          if (fg_fin) begin
            if (idx == LAST_DATA) begin
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= S_IDLE;
            end else begin
              idx <= idx_nx;
            end
          end
        end
        S_RX: begin
          if (rx_valid) begin
            rx_shift <= rx_next;
            if (idx == LAST_DATA) begin
              rdata <= rx_next;
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= S_IDLE;
            end else begin
              idx <= idx_nx;
            end
          end else if (rx_to) begin
            idx <= '0;
            if (!retried) begin
              retried <= 1'b1;
              state   <= S_BREAK;
            end else begin
              error  <= 1'b1;
              busy   <= 1'b0;
              synced <= 1'b0;
              state  <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  swh_frame_gen #(
    .BREAK_CLKS (BREAK_CLKS),
    .BRKREC_CLKS(BRKREC_CLKS),
    .LOW1_CLKS  (LOW1_CLKS),
    .LOW0_CLKS  (LOW0_CLKS),
    .CYCLE_CLKS (CYCLE_CLKS)
  ) u_frame (
    .clk      (clk),
    .rst      (rst),
    .start    (fg_start),
    .is_break (fg_brk),
    .bit_val  (fg_bit),
    .drive_low(drive_low),
    .fin      (fg_fin)
  );

  swh_pulse_meter #(
    .TIMEOUT_CLKS(TIMEOUT_CLKS),
    .THRESH_CLKS (THRESH_CLKS)
  ) u_meter (
    .clk      (clk),
    .rst      (rst),
    .arm      (rx_arm),
    .enable   (rx_en),
    .line_in  (line_in),
    .bit_valid(rx_valid),
    .bit_val  (rx_bit),
    .timeout  (rx_to)
  );
endmodule

// File: rtl/swh_host_chk.sv
module swh_host_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              drive_low,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic [DATA_W-1:0] rdata
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done && !error && !drive_low));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(rdata));

  assert_done_error_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(done && error));

  assert_busy_end_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done || error));

  assert_drive_in_access_R9: assert property (@(posedge clk) disable iff (rst)
    drive_low |-> busy);

  assert_finish_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (done || error) |-> $past(busy));
endmodule

bind swh_host swh_host_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .drive_low(drive_low),
  .busy     (busy),
  .done     (done),
  .error    (error),
  .rdata    (rdata)
);

// File: tb/sim_swh_host.sv
module sim_swh_host;
  localparam int BRK = 30;
  localparam int REC = 10;
  localparam int L1  = 4;
  localparam int L0  = 14;
  localparam int CYC = 20;
  localparam int TO  = 40;
  localparam int TH  = 7;
  localparam int SLAVE_ONE  = 3;
  localparam int SLAVE_ZERO = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_write = 1'b0;
  logic [6:0] req_addr  = '0;
  logic [7:0] req_wdata = '0;
  logic       slave_low = 1'b0;
  logic       line_in;
  logic       drive_low, busy, done, error;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;
  bit synced_model = 1'b0;
  bit exq[$];

  always #10 clk = ~clk;

  assign line_in = ~(drive_low | slave_low);

  swh_host #(
    .ADDR_W(7), .DATA_W(8),
    .BREAK_CLKS(BRK), .BRKREC_CLKS(REC), .LOW1_CLKS(L1), .LOW0_CLKS(L0),
    .CYCLE_CLKS(CYC), .TIMEOUT_CLKS(TO), .THRESH_CLKS(TH)
  ) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .line_in(line_in),
    .drive_low(drive_low), .busy(busy), .done(done), .error(error), .rdata(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push_frame(input bit b);
    int low = b ? L1 : L0;
    for (int i = 0; i < CYC; i++) exq.push_back(i < low);
  endtask

  task automatic push_break();
    for (int i = 0; i < BRK + REC; i++) exq.push_back(i < BRK);
  endtask

  task automatic push_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) push_frame(v[i]);
  endtask

  task automatic push_idle(input int n);
    for (int i = 0; i < n; i++) exq.push_back(1'b0);
  endtask

  task automatic issue(input bit w, input logic [6:0] a, input logic [7:0] d);
    req_write = w;
    req_addr  = a;
    req_wdata = d;
    req_valid = 1'b1;
  endtask

  // Compares {drive_low,busy,done,error} on every cycle of the queued access.
  task automatic run_expect(input string tag, input int hold);
    int n = exq.size();
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(tag, {28'd0, drive_low, busy, done, error}, {28'd0, exq[k], 3'b100});
      if (k == 0) begin
        req_addr  = req_addr ^ 7'h55;
        req_wdata = ~req_wdata;
        req_write = ~req_write;
      end
      if (k + 1 >= hold) req_valid = 1'b0;
    end
    exq.delete();
  endtask

  task automatic idle_tick(input string tag);
    @(negedge clk);
    chk(tag, {28'd0, drive_low, busy, done, error}, 32'd0);
  endtask

  task automatic slave_respond(input string tag, input logic [7:0] d);
    bit got = 1'b0;
    for (int j = 0; j < 8; j++) begin
      slave_low = 1'b0;
      repeat ((j == 0) ? 5 : 4) begin
        @(negedge clk);
        chk(tag, {28'd0, drive_low, busy, done, error}, 32'h4);
      end
      slave_low = 1'b1;
      repeat (d[j] ? SLAVE_ONE : SLAVE_ZERO) begin
        @(negedge clk);
        chk(tag, {28'd0, drive_low, busy, done, error}, 32'h4);
      end
    end
    slave_low = 1'b0;
    for (int w = 0; w < 10 && !got; w++) begin
      @(negedge clk);
      if (done) begin
        got = 1'b1;
        chk("R6 read data", {24'd0, rdata}, {24'd0, d});
        chk("R6 status at done", {30'd0, busy, error}, 32'd0);
      end else begin
        chk(tag, {28'd0, drive_low, busy, done, error}, 32'h4);
      end
    end
    if (!got) chk("R6 done missing", 32'd0, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R9 actual busy=%0b expected idle", busy);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {20'd0, drive_low, busy, done, error, rdata}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {20'd0, drive_low, busy, done, error, rdata}, 32'd0);

    // First write: break, command, data; request held while busy (R9).
    push_break();
    push_byte({1'b1, 7'h2A});
    push_byte(8'hC5);
    synced_model = 1'b1;
    issue(1'b1, 7'h2A, 8'hC5);
    run_expect("R2 R3 R4 R5 R9 first write", 6);
    @(negedge clk);
    chk("R5 done pulse", {28'd0, drive_low, busy, done, error}, 32'h2);
    idle_tick("R5 done single cycle");
    idle_tick("R9 idle after write");

    // Second write starts without a break (R10).
    push_byte({1'b1, 7'h7F});
    push_byte(8'h00);
    issue(1'b1, 7'h7F, 8'h00);
    run_expect("R10 R3 R5 write no break", 1);
    @(negedge clk);
    chk("R5 done pulse 2", {28'd0, drive_low, busy, done, error}, 32'h2);
    idle_tick("R10 idle");

    // Read with a prompt slave.
    push_byte({1'b0, 7'h11});
    issue(1'b0, 7'h11, 8'h00);
    run_expect("R3 R4 read command", 1);
    slave_respond("R6 read response", 8'hA6);
    idle_tick("R6 idle after read");

    // Read where the slave misses the first command (R7).
    push_byte({1'b0, 7'h05});
    push_idle(TO);
    push_break();
    push_byte({1'b0, 7'h05});
    issue(1'b0, 7'h05, 8'h00);
    run_expect("R7 timeout break resend", 1);
    slave_respond("R7 response after retry", 8'h3B);
    idle_tick("R7 idle");

    // Read with no answer at all (R8).
    push_byte({1'b0, 7'h40});
    push_idle(TO);
    push_break();
    push_byte({1'b0, 7'h40});
    push_idle(TO);
    issue(1'b0, 7'h40, 8'h00);
    run_expect("R8 double timeout", 1);
    @(negedge clk);
    chk("R8 error pulse", {28'd0, drive_low, busy, done, error}, 32'h1);
    chk("R8 rdata kept", {24'd0, rdata}, 32'h3B);
    idle_tick("R8 error single cycle");
    synced_model = 1'b0;

    // Write after the error restarts with a break (R8).
    push_break();
    push_byte({1'b1, 7'h00});
    push_byte(8'hFF);
    synced_model = 1'b1;
    issue(1'b1, 7'h00, 8'hFF);
    run_expect("R8 R2 break after error", 3);
    @(negedge clk);
    chk("R5 done after resync", {28'd0, drive_low, busy, done, error}, 32'h2);

    // Final read of all-zero data, long pulses only.
    push_byte({1'b0, 7'h7E});
    issue(1'b0, 7'h7E, 8'h00);
    run_expect("R10 R3 read no break", 1);
    slave_respond("R6 all zeros", 8'h00);
    idle_tick("R9 final idle");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule